// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command bus from the moment reset is released until the memory is ready for normal traffic. It holds clock enable high and issues no-operation commands for the power-up settling time. It then closes every bank with a single precharge and gives the device a fixed number of auto-refresh commands, each followed by its own recovery time. Last, it writes the mode register with an op-code assembled from the configuration inputs. After the mode-register recovery time it raises a ready flag and keeps the bus quiet.

All delays are given in nanoseconds, and the clock frequency is given in MHz. The block rounds every delay up to whole clock cycles. The configuration inputs select the burst length, burst ordering, CAS latency and write-burst behaviour. They must be held stable while the sequence runs.

If the configuration asks for a CAS latency or a burst length that the device reserves, the block does not load the mode register. It raises an error flag in the cycle where the load would have gone out, and the ready flag never rises.

Top module: `sdr_powerup_seq`

## Requirements
- R1: While reset is high, the bus carries NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1), the address and bank lines are zero, and init_done and cfg_error are low.
- R2: Counting rising edges after reset is released as edge 1, 2, ..., the bus carries NOP with a zero address on edges 1 through INIT_CK, where INIT_CK = ceil(T_INIT_NS*CLK_MHZ/1000).
- R3: On edge INIT_CK+1 the block issues precharge-all: command 0,0,1,0 with address bit 10 set, all other address bits zero, and bank zero.
- R4: Auto-refresh commands (0,0,0,1) with a zero address are issued NUM_REFRESH times (default two). The first comes TRP_CK edges after the precharge and each later one TRFC_CK edges after the previous one. NOP is issued on every edge in between.
- R5: TRFC_CK edges after the last refresh, the block issues a mode-register load (0,0,0,0). The address carries burst length on bits 2:0, burst ordering on bit 3, CAS latency on bits 6:4 and single-write mode on bit 9. Bits 8:7 and 11:10 are zero, and bank is zero.
- R6: init_done rises exactly MRD_CK edges after the mode-register load (default 2) and then stays high. From then on the bus carries NOP.
- R7: If the CAS latency code is not 010 or 011, or the burst length code is 100, 101 or 110, or it is 111 with interleaved ordering (bit 3 = 1), no load is issued. In that case cfg_error rises on the edge where the load would have gone out, init_done never rises, and the bus stays on NOP.
- R8: Every nanosecond delay is rounded up to whole clocks, with a minimum of one: TRP_CK = ceil(T_RP_NS*CLK_MHZ/1000) and TRFC_CK = ceil(T_RFC_NS*CLK_MHZ/1000).
- R9: sd_cke is high in reset and on every cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the sequence over |
| cfg_burst_len | input | 3 | Burst length code |
| cfg_interleave | input | 1 | Burst ordering: 0 sequential, 1 interleaved |
| cfg_cas_lat | input | 3 | CAS latency code |
| cfg_single_wr | input | 1 | 1: writes access a single location |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus |
| sd_ba | output | BA_W | Bank address |
| init_done | output | 1 | Device ready |
| cfg_error | output | 1 | Reserved configuration refused |

## Verification
The hardest situation to reach from the ports is the refusal path. A reserved configuration is only judged after the full settling wait and every refresh, so the case is reached only by running the whole sequence with such a code applied. The stimulus shortens the settling wait through a parameter override and runs complete sequences with several legal and several reserved codes, including a burst length code that is legal for one ordering and reserved for the other. It also pulses reset in the middle of a sequence to show that the schedule restarts cleanly.

// File: rtl/sdr_init_pkg.sv
package sdr_init_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdr_cmd_t;

    localparam sdr_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdr_cmd_t CMD_PRE  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sdr_cmd_t CMD_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam sdr_cmd_t CMD_LMR  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    typedef enum logic [2:0] {
        PH_POWERUP,
        PH_PRECHG,
        PH_REFRESH,
        PH_MODE,
        PH_READY,
        PH_FAULT
    } sdr_phase_e;

    // Round a delay in ns up to whole clocks, never below one.
    function automatic int ns_to_clk(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        if (c < 1) c = 1;
        return c;
    endfunction

    // Legal CAS latency and burst length codes.
    function automatic logic mode_legal(input logic [2:0] bl, input logic bt,
                                        input logic [2:0] cl);
        logic cl_ok, bl_ok;
        cl_ok = (cl == 3'd2) || (cl == 3'd3);
        bl_ok = (bl <= 3'd3) || ((bl == 3'd7) && !bt);
        return cl_ok && bl_ok;
    endfunction

endpackage

// File: rtl/sdr_wait_timer.sv
module sdr_wait_timer #(
    parameter int W         = 8,
    parameter int RESET_VAL = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst)
            count <= W'(RESET_VAL);
        else if (load)
            count <= load_val;
        else if (count != '0)
            count <= count - 1'b1;
    end

    assign expired = (count == '0);
endmodule

// File: rtl/sdr_mode_word.sv
module sdr_mode_word
    import sdr_init_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [2:0]        bl,
    input  logic              bt,
    input  logic [2:0]        cl,
    input  logic              wb,
    output logic [ADDR_W-1:0] word,
    output logic              legal
);
    always_comb begin
        word      = '0;
        word[2:0] = bl;
        word[3]   = bt;
        word[6:4] = cl;
        word[9]   = wb;
        legal     = mode_legal(bl, bt, cl);
    end
endmodule

// File: rtl/sdr_cmd_reg.sv
module sdr_cmd_reg
    import sdr_init_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  sdr_cmd_t          cmd_d,
    input  logic [ADDR_W-1:0] addr_d,
    output sdr_cmd_t          cmd_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [BA_W-1:0]   ba_q,
    output logic              cke_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= CMD_NOP;
            addr_q <= '0;
            ba_q   <= '0;
            cke_q  <= 1'b1;
        end else begin
            cmd_q  <= cmd_d;
            addr_q <= addr_d;
            ba_q   <= '0;
            cke_q  <= 1'b1;
        end
    end
endmodule

// File: rtl/sdr_powerup_seq.sv
module sdr_powerup_seq
    import sdr_init_pkg::*;
#(
    parameter int CLK_MHZ     = 100,
    parameter int T_INIT_NS   = 100000,
    parameter int T_RP_NS     = 20,
    parameter int T_RFC_NS    = 70,
    parameter int MRD_CK      = 2,
    parameter int NUM_REFRESH = 2,
    parameter int ADDR_W      = 12,
    parameter int BA_W        = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_interleave,
    input  logic [2:0]        cfg_cas_lat,
    input  logic              cfg_single_wr,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba,
    output logic              init_done,
    output logic              cfg_error
);
    localparam int INIT_CK = ns_to_clk(T_INIT_NS, CLK_MHZ);
    localparam int TRP_CK  = ns_to_clk(T_RP_NS, CLK_MHZ);
    localparam int TRFC_CK = ns_to_clk(T_RFC_NS, CLK_MHZ);
    localparam int MAX_CK  = (INIT_CK > TRFC_CK) ? INIT_CK : TRFC_CK;
    localparam int TW      = $clog2(MAX_CK + MRD_CK + TRP_CK + 1);
    localparam int RCW     = $clog2(NUM_REFRESH + 1);

    sdr_phase_e        phase, phase_nxt;
    logic [RCW-1:0]    ref_cnt, ref_cnt_nxt;
    logic              done_nxt, err_nxt;
    logic              tmr_load, tmr_zero;
    logic [TW-1:0]     tmr_val;
    sdr_cmd_t          cmd_nxt, cmd_q;
    logic [ADDR_W-1:0] addr_nxt;
    logic [ADDR_W-1:0] mode_word;
    logic              mode_ok;

    sdr_wait_timer #(.W(TW), .RESET_VAL(INIT_CK)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_zero)
    );

    sdr_mode_word #(.ADDR_W(ADDR_W)) u_mode (
        .bl(cfg_burst_len), .bt(cfg_interleave), .cl(cfg_cas_lat),
        .wb(cfg_single_wr), .word(mode_word), .legal(mode_ok)
    );

    always_comb begin
        phase_nxt   = phase;
        ref_cnt_nxt = ref_cnt;
        done_nxt    = init_done;
        err_nxt     = cfg_error;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        cmd_nxt     = CMD_NOP;
        addr_nxt    = '0;
        if (tmr_zero) begin
            unique case (phase)
                PH_POWERUP: begin
                    cmd_nxt      = CMD_PRE;
                    addr_nxt[10] = 1'b1;
                    phase_nxt    = PH_PRECHG;
                    tmr_load     = 1'b1;
                    tmr_val      = TW'(TRP_CK - 1);
                end
                PH_PRECHG, PH_REFRESH: begin
                    if (phase == PH_PRECHG || ref_cnt < RCW'(NUM_REFRESH)) begin
                        cmd_nxt     = CMD_REF;
                        phase_nxt   = PH_REFRESH;
                        ref_cnt_nxt = (phase == PH_PRECHG) ? RCW'(1) : ref_cnt + 1'b1;
                        tmr_load    = 1'b1;
                        tmr_val     = TW'(TRFC_CK - 1);
                    end else if (mode_ok) begin
                        cmd_nxt   = CMD_LMR;
                        addr_nxt  = mode_word;
                        phase_nxt = PH_MODE;
                        tmr_load  = 1'b1;
                        tmr_val   = TW'(MRD_CK - 1);
                    end else begin
                        phase_nxt = PH_FAULT;
                        err_nxt   = 1'b1;
                    end
                end
                PH_MODE: begin
                    phase_nxt = PH_READY;
                    done_nxt  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_POWERUP;
            ref_cnt   <= '0;
            init_done <= 1'b0;
            cfg_error <= 1'b0;
        end else begin
            phase     <= phase_nxt;
            ref_cnt   <= ref_cnt_nxt;
            init_done <= done_nxt;
            cfg_error <= err_nxt;
        end
    end

    sdr_cmd_reg #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_out (
        .clk(clk), .rst(rst), .cmd_d(cmd_nxt), .addr_d(addr_nxt),
        .cmd_q(cmd_q), .addr_q(sd_addr), .ba_q(sd_ba), .cke_q(sd_cke)
    );

    assign sd_cs_n  = cmd_q.cs_n;
    assign sd_ras_n = cmd_q.ras_n;
    assign sd_cas_n = cmd_q.cas_n;
    assign sd_we_n  = cmd_q.we_n;

    // Assertions
    logic [3:0] bus_cmd;
    assign bus_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    assert_legal_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == 4'b0111 || bus_cmd == 4'b0010 || bus_cmd == 4'b0001 || bus_cmd == 4'b0000));

    assert_pre_all_banks_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == 4'b0010) |-> sd_addr[10]);

    assert_lmr_reserved_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == 4'b0000) |-> (sd_addr[11:10] == 2'b00 && sd_addr[8:7] == 2'b00
                                  && (sd_addr[6:4] == 3'd2 || sd_addr[6:4] == 3'd3)));

    assert_lmr_then_nop_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == 4'b0000) |=> (bus_cmd == 4'b0111 && !init_done));

    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        init_done |=> (init_done && bus_cmd == 4'b0111));

    assert_err_excludes_done_R7: assert property (@(posedge clk) disable iff (rst)
        !(init_done && cfg_error));

    assert_err_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_error |-> (bus_cmd == 4'b0111));
endmodule

// File: tb/tb_sdr_powerup_seq.sv
module tb_sdr_powerup_seq;
    // Expected derived delays for the override values below (R8):
    // 1500 ns @100 MHz -> 150, 25 ns -> 3 (rounded up), 65 ns -> 7 (rounded up)
    localparam int E_INIT = 150;
    localparam int E_TRP  = 3;
    localparam int E_TRFC = 7;
    localparam int E_MRD  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bl = 3'd0, cl = 3'd2;
    logic        bt = 1'b0, wb = 1'b0;
    logic        cke, cs_n, ras_n, cas_n, we_n, done, err;
    logic [11:0] addr;
    logic [1:0]  ba;

    int checks = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sdr_powerup_seq #(
        .CLK_MHZ(100), .T_INIT_NS(1500), .T_RP_NS(25), .T_RFC_NS(65),
        .MRD_CK(2), .NUM_REFRESH(2), .ADDR_W(12), .BA_W(2)
    ) dut (
        .clk(clk), .rst(rst), .cfg_burst_len(bl), .cfg_interleave(bt),
        .cfg_cas_lat(cl), .cfg_single_wr(wb), .sd_cke(cke), .sd_cs_n(cs_n),
        .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_addr(addr),
        .sd_ba(ba), .init_done(done), .cfg_error(err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic bit cfg_ok(input logic [2:0] b, input logic t, input logic [2:0] c);
        bit c_good = (c == 3'b010) || (c == 3'b011);
        bit b_good = (b == 3'd0) || (b == 3'd1) || (b == 3'd2) || (b == 3'd3)
                   || (b == 3'd7 && t == 1'b0);
        return c_good && b_good;
    endfunction

    // Compare the bus after edge n (n counted from reset release) against the model.
    task automatic compare(input int n);
        int pre_at  = E_INIT + 1;
        int r1_at   = pre_at + E_TRP;
        int r2_at   = r1_at + E_TRFC;
        int lmr_at  = r2_at + E_TRFC;
        int done_at = lmr_at + E_MRD;
        bit ok      = cfg_ok(bl, bt, cl);
        int op      = (int'(wb) << 9) | (int'(cl) << 4) | (int'(bt) << 3) | int'(bl);
        int e_cmd   = 4'b0111;
        int e_addr  = 0;
        string tag  = "R2";
        int a_cmd   = {cs_n, ras_n, cas_n, we_n};
        if (n == pre_at) begin e_cmd = 4'b0010; e_addr = 12'h400; tag = "R3"; end
        else if (n == r1_at || n == r2_at) begin e_cmd = 4'b0001; tag = "R4 R8"; end
        else if (n == lmr_at && ok) begin e_cmd = 4'b0000; e_addr = op; tag = "R5"; end
        else if (n > pre_at && n < lmr_at) tag = "R4";
        else if (n >= lmr_at) tag = ok ? "R6" : "R7";
        check(a_cmd == e_cmd, tag, $sformatf("cmd edge %0d", n), a_cmd, e_cmd);
        check(addr == 12'(e_addr) && ba == 2'd0, tag, $sformatf("addr edge %0d", n),
              int'(addr), e_addr);
        check(done == (ok && n >= done_at), ok ? "R6" : "R7",
              $sformatf("done edge %0d", n), int'(done), int'(ok && n >= done_at));
        check(err == (!ok && n >= lmr_at), "R7", $sformatf("err edge %0d", n),
              int'(err), int'(!ok && n >= lmr_at));
        check(cke == 1'b1, "R9", $sformatf("cke edge %0d", n), int'(cke), 1);
    endtask

    task automatic run_seq(input logic [2:0] b, input logic t, input logic [2:0] c,
                           input logic w, input int edges);
        @(negedge clk);
        rst = 1'b1; bl = b; bt = t; cl = c; wb = w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", "reset cmd",
              int'({cs_n, ras_n, cas_n, we_n}), 4'b0111);
        check(addr == 0 && ba == 0, "R1", "reset addr", int'(addr), 0);
        check(!done && !err, "R1", "reset flags", int'({done, err}), 0);
        check(cke == 1'b1, "R9", "reset cke", int'(cke), 1);
        rst = 1'b0;
        for (int n = 1; n <= edges; n++) begin
            @(posedge clk);
            @(negedge clk);
            compare(n);
        end
    endtask

    initial begin
        int full = E_INIT + 1 + E_TRP + 2 * E_TRFC + E_MRD + 12;
        run_seq(3'd3, 1'b0, 3'd2, 1'b0, full);   // BL8 sequential CL2
        run_seq(3'd7, 1'b0, 3'd3, 1'b1, full);   // full page, single writes, CL3
        run_seq(3'd2, 1'b1, 3'd3, 1'b0, 60);     // partial run, then reset mid-wait
        run_seq(3'd2, 1'b1, 3'd3, 1'b0, full);   // BL4 interleaved after restart
        run_seq(3'd0, 1'b0, 3'd4, 1'b0, full);   // R7 reserved CAS latency
        run_seq(3'd5, 1'b0, 3'd2, 1'b0, full);   // R7 reserved burst length
        run_seq(3'd7, 1'b1, 3'd3, 1'b0, full);   // R7 full page with interleave
        run_seq(3'd1, 1'b0, 3'd0, 1'b1, full);   // R7 CAS latency code 000
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000 && !finished) begin
                finished = 1;
                checks++;
                bad++;
                $display("FAIL watchdog expired actual=%0d expected<=200000", cycles);
                $display("  test done: total=%0d bad=%0d", checks, bad);
                $finish;
            end
        end
    end
endmodule